// File: doc/BRIEF.md
# One-Time-Programmable Bit Array Controller

This block is a byte-wide register peripheral that gives a small 8-bit processor access to a 64-cell one-time-programmable bit array, one cell at a time. Software writes a cell number into a select register. It then reads a status/control register to see the sensed value of that cell. To burn the selected cell, it sets the programming-enable control and waits a fixed number of clocks.

The cell number is split into a row (the low three bits) and a column (the next three bits). The two upper bits of the select register are plain storage. The status/control register returns four things: the sensed data bit; a flag that is set whenever the selected row is row zero; the enable control; and zeros elsewhere.

The array is modelled behaviourally. It starts fully erased, and a cell can only go from 0 to 1. The sensed data bit is held in a register that reset leaves untouched.

Top module: `otp_bitarray_ctrl`

## Requirements
- R1: A write with `wr_i` high takes effect on the rising clock edge. Address 0x0E reaches the select register and address 0x0F reaches the status/control register. A write to any other address changes nothing.
- R2: Select bits 2..0 give the row and bits 5..3 give the column. Together they address cell number column*8+row, so different selections reach independent cells.
- R3: Select bits 7 and 6 are read/write storage. They read back as written and have no effect on which cell is addressed.
- R4: A synchronous reset (`rst_i` high) clears the whole select register, which selects row 0, column 0. It also clears the programming-enable control.
- R5: Reading the status/control register returns the following. Bit 7 is the sensed data bit. Bits 6..2 read as 0. Bit 1 reads 1 exactly when select bits 2..0 are zero. Bit 0 is the enable control. A write to this register changes only bit 0.
- R6: Reset does not change the sensed data bit.
- R7: The sensed data bit takes the value of the selected cell on the second clock edge after a select write. It does the same on the edge after the edge on which a cell gets programmed. It keeps its value at all other times.
- R8: While enable is 1 and no select write occurs, the selected cell is set to 1 on the PROG_CYCLES-th edge after enable was set. A select write restarts the count, and so does clearing enable. A cell changes only while enable is 1.
- R9: All cells start at 0. A programmed cell never returns to 0, whatever the later selection, enable or reset.
- R10: `rdata_o` is 0 when `rd_i` is low, and also when the read address is neither 0x0E nor 0x0F.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| addr_i | input | 8 | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from address and strobe |

## Verification
The select register is loaded with several kinds of values:
- values that differ only in the storage bits, which separate a correct readback from a truncated one;
- values with a zero row and a non-zero row, which separate the flag decode from the column bits;
- pairs that swap row and column, which show that cells are independent.

The enable is tried in three ways, which together tell a correct timer from one that fires early, fires late, or fails to restart:
- held for the full count;
- interrupted by a select write mid-count;
- held again on a cell that is already programmed.

A reset while the data bit is 1 separates a retained sense register from one that is cleared. Reads at neighbouring addresses, and reads with the strobe low, expose a read mux that leaks.

// File: rtl/otp_bitarray_pkg.sv
package otp_bitarray_pkg;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_SEL  = 2'd1,
      TGT_CTL  = 2'd2
   } reg_tgt_e;

   // bit positions in the status/control register that neighbours decode
   localparam int CTL_EN_BIT   = 0;
   localparam int CTL_ROWZ_BIT = 1;

endpackage

// File: rtl/otp_bus_decode.sv
module otp_bus_decode
   import otp_bitarray_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h0E,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0F
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output reg_tgt_e          wr_tgt_o,
   output reg_tgt_e          rd_tgt_o
);

   reg_tgt_e hit;

   always_comb begin
      hit = TGT_NONE;
      if (addr_i == SEL_ADDR) begin
         hit = TGT_SEL;
      end else if (addr_i == CTL_ADDR) begin
         hit = TGT_CTL;
      end
   end

   assign wr_tgt_o = wr_i ? hit : TGT_NONE;
   assign rd_tgt_o = rd_i ? hit : TGT_NONE;

endmodule

// File: rtl/otp_select_ctl.sv
module otp_select_ctl
   import otp_bitarray_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  reg_tgt_e          wr_tgt_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] sel_o,
   output logic              en_o,
   output logic              sel_wr_o
);

   logic [DATA_W-1:0] sel_q;
   logic              en_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sel_q <= '0;
         en_q  <= 1'b0;
      end else begin
         if (wr_tgt_i == TGT_SEL) begin
            sel_q <= wdata_i;
         end
         if (wr_tgt_i == TGT_CTL) begin
            en_q <= wdata_i[CTL_EN_BIT];
         end
      end
   end

   assign sel_o    = sel_q;
   assign en_o     = en_q;
   assign sel_wr_o = (wr_tgt_i == TGT_SEL);

endmodule

// File: rtl/otp_prog_timer.sv
module otp_prog_timer #(
   parameter int PROG_CYCLES = 16,
   localparam int CNT_W      = $clog2(PROG_CYCLES + 1)
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic en_i,
   input  logic restart_i,
   output logic fire_o
);

   localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(PROG_CYCLES);

   logic [CNT_W-1:0] cnt_q;

   // saturates at FULL so a held enable fires exactly once per selection
   always_ff @(posedge clk_i) begin
      if (rst_i || !en_i || restart_i) begin
         cnt_q <= '0;
      end else if (cnt_q != FULL) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign fire_o = en_i && !restart_i && (cnt_q == LAST);

endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
   parameter int IDX_W  = 6,
   localparam int CELLS = 1 << IDX_W
) (
   input  logic             clk_i,
   input  logic             fire_i,
   input  logic [IDX_W-1:0] idx_i,
   output logic [CELLS-1:0] cells_o,
   output logic             bit_o
);

   for (genvar g = 0; g < CELLS; g++) begin : g_cell
      // non-volatile: starts erased, never touched by reset
      logic cell_q = 1'b0;
      always_ff @(posedge clk_i) begin
         if (fire_i && (idx_i == IDX_W'(g))) begin
            cell_q <= 1'b1;
         end
      end
      assign cells_o[g] = cell_q;
   end

   assign bit_o = cells_o[idx_i];

endmodule

// File: rtl/otp_sense.sv
module otp_sense (
   input  logic clk_i,
   input  logic rst_i,
   input  logic update_i,
   input  logic bit_i,
   output logic upd_o,
   output logic data_o
);

   logic upd_q;
   logic data_q = 1'b0;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         upd_q <= 1'b0;
      end else begin
         upd_q <= update_i;
      end
   end

   // no reset branch: the sensed value survives reset
   always_ff @(posedge clk_i) begin
      if (upd_q) begin
         data_q <= bit_i;
      end
   end

   assign upd_o  = upd_q;
   assign data_o = data_q;

endmodule

// File: rtl/otp_bitarray_ctrl.sv
module otp_bitarray_ctrl
   import otp_bitarray_pkg::*;
#(
   parameter int                ADDR_W      = 8,
   parameter int                DATA_W      = 8,
   parameter int                ROW_W       = 3,
   parameter int                COL_W       = 3,
   parameter int                PROG_CYCLES = 16,
   parameter logic [ADDR_W-1:0] SEL_ADDR    = 8'h0E,
   parameter logic [ADDR_W-1:0] CTL_ADDR    = 8'h0F
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int IDX_W = ROW_W + COL_W;
   localparam int CELLS = 1 << IDX_W;

   if (ROW_W < 1 || COL_W < 1) begin : g_bad_geom
      $error("row and column fields need at least one bit each");
   end
   if (IDX_W > DATA_W) begin : g_bad_idx
      $error("cell index does not fit in the select register");
   end
   if (DATA_W < 3) begin : g_bad_data
      $error("status layout needs at least three bits");
   end
   if (PROG_CYCLES < 1) begin : g_bad_prog
      $error("programming time must be at least one cycle");
   end
   if (SEL_ADDR == CTL_ADDR) begin : g_bad_addr
      $error("register addresses must differ");
   end

   reg_tgt_e          wr_tgt;
   reg_tgt_e          rd_tgt;
   logic [DATA_W-1:0] sel_q;
   logic              en_q;
   logic              sel_wr;
   logic              fire;
   logic [CELLS-1:0]  cells;
   logic              cell_bit;
   logic              upd_q;
   logic              dat_q;
   logic [IDX_W-1:0]  idx;
   logic [ROW_W-1:0]  row;
   logic [DATA_W-1:0] stat;

   otp_bus_decode #(
      .ADDR_W  (ADDR_W),
      .SEL_ADDR(SEL_ADDR),
      .CTL_ADDR(CTL_ADDR)
   ) u_dec (
      .addr_i  (addr_i),
      .wr_i    (wr_i),
      .rd_i    (rd_i),
      .wr_tgt_o(wr_tgt),
      .rd_tgt_o(rd_tgt)
   );

   otp_select_ctl #(.DATA_W(DATA_W)) u_regs (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .wr_tgt_i(wr_tgt),
      .wdata_i (wdata_i),
      .sel_o   (sel_q),
      .en_o    (en_q),
      .sel_wr_o(sel_wr)
   );

   assign idx = sel_q[IDX_W-1:0];
   assign row = sel_q[ROW_W-1:0];

   otp_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_q),
      .restart_i(sel_wr),
      .fire_o   (fire)
   );

   otp_cell_array #(.IDX_W(IDX_W)) u_array (
      .clk_i  (clk_i),
      .fire_i (fire),
      .idx_i  (idx),
      .cells_o(cells),
      .bit_o  (cell_bit)
   );

   otp_sense u_sense (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .update_i(sel_wr || fire),
      .bit_i   (cell_bit),
      .upd_o   (upd_q),
      .data_o  (dat_q)
   );

   always_comb begin
      stat               = '0;
      stat[DATA_W-1]     = dat_q;
      stat[CTL_ROWZ_BIT] = (row == '0);
      stat[CTL_EN_BIT]   = en_q;
   end

   always_comb begin
      unique case (rd_tgt)
         TGT_SEL: rdata_o = sel_q;
         TGT_CTL: rdata_o = stat;
         default: rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/otp_bitarray_chk.sv
module otp_bitarray_chk #(
   parameter int                ADDR_W   = 8,
   parameter int                DATA_W   = 8,
   parameter int                ROW_W    = 3,
   parameter int                IDX_W    = 6,
   parameter int                CELLS    = 64,
   parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h0E,
   parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h0F
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic [ADDR_W-1:0] addr_i,
   input logic              rd_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic [ROW_W-1:0]  row,
   input logic              en_q,
   input logic [CELLS-1:0]  cells,
   input logic              dat_q,
   input logic              upd_q,
   input logic [IDX_W-1:0]  idx
);

   // R9
   cells_monotonic_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (($past(cells) & ~cells) == '0));

   // R8
   cells_need_enable_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable(cells) |-> $past(en_q));

   // R8
   one_cell_per_edge_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      $countones(cells ^ $past(cells)) <= 1);

   // R7
   data_follows_cell_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      upd_q |=> (dat_q == $past(cells[idx])));

   // R5
   ctl_reserved_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_i && addr_i == CTL_ADDR) |-> (rdata_o[DATA_W-2:2] == '0));

   // R5
   row_flag_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_i && addr_i == CTL_ADDR) |-> (rdata_o[1] == (row == '0)));

   // R10
   idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!rd_i || (addr_i != SEL_ADDR && addr_i != CTL_ADDR)) |-> (rdata_o == '0));

endmodule

bind otp_bitarray_ctrl otp_bitarray_chk #(
   .ADDR_W  (ADDR_W),
   .DATA_W  (DATA_W),
   .ROW_W   (ROW_W),
   .IDX_W   (IDX_W),
   .CELLS   (CELLS),
   .SEL_ADDR(SEL_ADDR),
   .CTL_ADDR(CTL_ADDR)
) u_chk (
   .clk_i  (clk_i),
   .rst_i  (rst_i),
   .addr_i (addr_i),
   .rd_i   (rd_i),
   .rdata_o(rdata_o),
   .row    (row),
   .en_q   (en_q),
   .cells  (cells),
   .dat_q  (dat_q),
   .upd_q  (upd_q),
   .idx    (idx)
);

// File: tb/otp_bitarray_ctrl_bench.sv
`timescale 1ns/1ps
module otp_bitarray_ctrl_bench;

   localparam int PROG = 16;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] addr = 8'h00;
   logic       wr = 1'b0;
   logic       rd = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;

   int    checks = 0;
   int    errors = 0;
   bit    cmp_on = 1'b0;
   string cur_req = "R4";

   // reference model state
   int m_sel = 0;
   bit m_en = 0;
   bit m_upd = 0;
   bit m_dat = 0;
   int m_cnt = 0;
   bit m_cells [64];

   always #4 clk = ~clk;

   otp_bitarray_ctrl #(.PROG_CYCLES(PROG)) u_otp_bitarray_ctrl (
      .clk_i  (clk),
      .rst_i  (rst),
      .addr_i (addr),
      .wr_i   (wr),
      .rd_i   (rd),
      .wdata_i(wdata),
      .rdata_o(rdata)
   );

   always @(posedge clk) begin
      bit sw, cw, fire;
      if (rst) begin
         m_sel = 0; m_en = 0; m_upd = 0; m_cnt = 0;
      end else begin
         sw   = wr && addr == 8'h0E;
         cw   = wr && addr == 8'h0F;
         fire = m_en && !sw && (m_cnt == PROG - 1);
         if (m_upd) m_dat = m_cells[m_sel % 64];
         if (fire) m_cells[m_sel % 64] = 1'b1;
         if (!m_en || sw) m_cnt = 0;
         else if (m_cnt < PROG) m_cnt++;
         m_upd = sw || fire;
         if (sw) m_sel = int'(wdata);
         if (cw) m_en = wdata[0];
      end
   end

   function automatic logic [7:0] model_read();
      if (!rd) return 8'h00;
      if (addr == 8'h0E) return 8'(m_sel);
      if (addr == 8'h0F) return {m_dat, 5'b0, (m_sel % 8) == 0, m_en};
      return 8'h00;
   endfunction

   task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h t=%0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) begin
         #2;
         check(rdata, model_read(), cur_req);
      end
   end

   task automatic drive(input logic w, input logic r, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr = w; rd = r; addr = a; wdata = d;
   endtask

   task automatic idle(input int n);
      repeat (n) drive(1'b0, 1'b1, 8'h0F, 8'h00);
   endtask

   task automatic expect_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
      drive(1'b0, 1'b1, a, 8'h00);
      #2;
      check(rdata, exp, req);
   endtask

   task automatic wr_sel(input logic [7:0] d);
      drive(1'b1, 1'b0, 8'h0E, d);
   endtask

   task automatic wr_ctl(input logic [7:0] d);
      drive(1'b1, 1'b0, 8'h0F, d);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R8 actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp_on = 1'b1;
      idle(1);
      rst = 1'b0;
      // R4: reset state, R5 flag set for row zero
      cur_req = "R4";
      expect_rd(8'h0E, 8'h00, "R4");
      expect_rd(8'h0F, 8'h02, "R5");
      // R1: write to a neighbouring address is ignored
      cur_req = "R1";
      drive(1'b1, 1'b0, 8'h0D, 8'hFF);
      expect_rd(8'h0E, 8'h00, "R1");
      // R3: storage bits read back, row zero flag stays
      cur_req = "R3";
      wr_sel(8'hC0);
      idle(1);
      expect_rd(8'h0E, 8'hC0, "R3");
      expect_rd(8'h0F, 8'h02, "R3");
      // R5: non-zero row clears the flag; only bit 0 of control is writable
      cur_req = "R5";
      wr_sel(8'h2B);
      idle(1);
      expect_rd(8'h0F, 8'h00, "R5");
      wr_ctl(8'hFE);
      expect_rd(8'h0F, 8'h00, "R5");
      // R8: full programming window on cell 0x2B
      cur_req = "R8";
      wr_ctl(8'h01);
      idle(PROG + 2);
      expect_rd(8'h0F, 8'h81, "R8");
      wr_ctl(8'h00);
      // R7: new selection senses an erased cell one clock later
      cur_req = "R7";
      wr_sel(8'h05);
      expect_rd(8'h0F, 8'h80, "R7");
      expect_rd(8'h0F, 8'h00, "R7");
      // R8: interrupted window restarts the count
      cur_req = "R8";
      wr_ctl(8'h01);
      idle(PROG - 4);
      wr_sel(8'h06);
      idle(5);
      wr_ctl(8'h00);
      wr_sel(8'h05);
      idle(1);
      expect_rd(8'h0F, 8'h00, "R8");
      wr_sel(8'h06);
      idle(1);
      expect_rd(8'h0F, 8'h00, "R8");
      // R2: row/column cells are independent
      cur_req = "R2";
      wr_sel(8'h08);
      wr_ctl(8'h01);
      idle(PROG + 2);
      wr_ctl(8'h00);
      expect_rd(8'h0F, 8'h82, "R2");
      wr_sel(8'h01);
      idle(1);
      expect_rd(8'h0F, 8'h00, "R2");
      wr_sel(8'h08);
      idle(1);
      expect_rd(8'h0F, 8'h82, "R2");
      // R9: programmed cell stays 1 under a second window
      cur_req = "R9";
      wr_sel(8'h2B);
      idle(1);
      expect_rd(8'h0F, 8'h80, "R9");
      wr_ctl(8'h01);
      idle(PROG + 4);
      wr_ctl(8'h00);
      expect_rd(8'h0F, 8'h80, "R9");
      // R6: reset keeps the sensed bit
      cur_req = "R6";
      @(negedge clk);
      rst = 1'b1;
      idle(3);
      rst = 1'b0;
      expect_rd(8'h0E, 8'h00, "R6");
      expect_rd(8'h0F, 8'h82, "R6");
      // R9: cell still programmed after reset
      cur_req = "R9";
      wr_sel(8'h2B);
      idle(1);
      expect_rd(8'h0F, 8'h80, "R9");
      // R10: other addresses and strobe low read zero
      cur_req = "R10";
      expect_rd(8'h00, 8'h00, "R10");
      expect_rd(8'h10, 8'h00, "R10");
      expect_rd(8'h0D, 8'h00, "R10");
      drive(1'b0, 1'b0, 8'h0E, 8'h00);
      #2;
      check(rdata, 8'h00, "R10");
      idle(2);
      cmp_on = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule